// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block is the host end of an enhanced parallel port. Software accesses come in one at a time on a valid/ready request stream carrying a register offset, a direction, an access size and write data. Every request gets exactly one reply on a valid/ready response stream. Offsets 0 to 2 hold the data latch, the status view and the control register. Offset 3 runs address cycles and offset 4 runs data cycles on an 8-bit bidirectional peripheral bus. That bus uses active-low address and data strobes, an active-low write line and a `wait_i` line from the peripheral.

Before a cycle starts, the control register is checked against an exact bit pattern. Reads and writes use different patterns. If the check fails, the access finishes at once with no bus activity. Data accesses of 16 or 32 bits are split into byte cycles, least significant byte first. Each byte cycle is a setup / strobe / release handshake with a timeout. If the peripheral does not respond in time, the transfer is aborted and a sticky timeout flag is set. Software sees the flag in bit 0 of the status register and clears it by writing a 1 there.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its fields must stay stable while `req_valid` is high. `req_ready` is low while a bus transfer is running or while a reply has not yet been taken. `rsp_valid` and `rsp_rdata` are held unchanged until `rsp_ready` is high.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, the control register reads 0xCC and `ctrl_o` is 0xCC. The data latch is 0xFF and the timeout flag is clear. Both strobes and `nwrite_o` are high, and `pd_oe_o` is high because control bit 5 is 0.
- R2: A write to offset 3 or 4 starts a bus cycle only when (control & 0x2F) == 0x04. Otherwise no strobe is asserted and the reply comes back with data 0.
- R3: A read from offset 3 or 4 starts a bus cycle only when (control & 0x2F) == 0x24. Otherwise no strobe is asserted and the reply is all ones at the access width. `req_size` 0 gives 0xFF, 1 gives 0xFFFF, and 2 or 3 gives 0xFFFFFFFF.
- R4: Offset 3 moves exactly one byte under `naddr_stb_o`. Offset 4 uses `ndata_stb_o`. The two strobes are never low together.
- R5: An access to offset 4 of size 1 moves 2 bytes and an access of size 2 or 3 moves 4 bytes, least significant byte first. Read bytes are assembled in the same order.
- R6: Each byte cycle sets up `nwrite_o` (low for a write) and the data bus one clock before the strobe falls. The strobe stays low until `wait_i` is seen high and is then released. The next byte starts only after `wait_i` is seen low.
- R7: During a read cycle `pd_oe_o` is low, and the byte on `pd_i` is captured in the clock where `wait_i` is first seen high.
- R8: If `wait_i` does not change within TIMEOUT_CYCLES clocks in either wait phase, the cycle aborts. Both strobes are released, the timeout flag is set, the remaining bytes are dropped, and any bytes not yet received read as 0xFF.
- R9: A status read (offset 1) returns `ext_status_i[7:1]` in bits 7:1 and the timeout flag in bit 0.
- R10: A status write with bit 0 = 1 clears the timeout flag. A write with bit 0 = 0 leaves it unchanged.
- R11: A control write (offset 2) stores the value with bits 7:6 forced to 1. `ctrl_upd_o` pulses for one clock only if the stored value changes, and bits 7:6 of `ctrl_o` are always 1.
- R12: A data-latch write (offset 0) updates `pd_o` and pulses `data_upd_o` only when the value differs from the stored one. A read of offset 0 returns the latch when control bit 5 is 0 and `pd_i` when it is 1.
- R13: Every accepted request yields exactly one reply. `req_ready` is low while a reply is pending, and a reply is held stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_size | input | 2 | 0 = 8, 1 = 16, 2/3 = 32 bit (data cycles only) |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply taken |
| rsp_rdata | output | WORD_W | Read data (0 for writes) |
| ext_status_i | input | 8 | External status lines |
| ctrl_o | output | 8 | Stored control register |
| ctrl_upd_o | output | 1 | Control changed pulse |
| data_upd_o | output | 1 | Data latch changed pulse |
| pd_o | output | 8 | Peripheral data out |
| pd_i | input | 8 | Peripheral data in |
| pd_oe_o | output | 1 | Peripheral data output enable |
| nwrite_o | output | 1 | Write line, low = write |
| naddr_stb_o | output | 1 | Address strobe, active low |
| ndata_stb_o | output | 1 | Data strobe, active low |
| wait_i | input | 1 | Peripheral handshake line |

## Verification
The assertions check on every cycle that the two strobes are never low together and that the bus is not driven during a read strobe. They also check that the write line is settled when a strobe falls, that a held reply does not change, that `ctrl_o` bits 7:6 stay 1 and change only with an update pulse, and that a status write with bit 0 set leaves the flag clear. Only the bench scenarios can show the gating patterns for each control value, the byte order of wide transfers, the all-ones rejected replies, and the timeout aborting partway through a transfer with the remaining bytes dropped. The same holds for suppressing updates when a value repeats and for choosing between the latch and `pd_i` on data reads.

// File: rtl/epp_eng_pkg.sv
package epp_eng_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_EADR = 3'd3;
  localparam logic [2:0] OFS_EDAT = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] CTRL_INIT  = 8'hCC;
  localparam int         DIR_BIT    = 5;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_SETUP,
    HS_STROBE,
    HS_RELEASE
  } hs_state_e;
endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int NB  = WORD_W / 8,
  localparam int NBW = $clog2(NB) + 1
) (
  input  logic [7:0]        ctrl_i,
  input  logic              is_write_i,
  input  logic [1:0]        size_i,
  output logic              allow_o,
  output logic [NBW-1:0]    nbytes_o,
  output logic [WORD_W-1:0] ones_o
);
  logic [7:0] want;

  always_comb begin
    want    = is_write_i ? GATE_WR : GATE_RD;
    allow_o = ((ctrl_i & GATE_MASK) == want);
  end

  always_comb begin
    case (size_i)
      2'd0:    nbytes_o = NBW'(1);
      2'd1:    nbytes_o = (NB >= 2) ? NBW'(2) : NBW'(NB);
      default: nbytes_o = NBW'(NB);
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : g_mask
    assign ones_o[g*8 +: 8] = (NBW'(g) < nbytes_o) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/epp_timer.sv
module epp_timer #(
  parameter int LIMIT = 1000,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  logic [TW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (run_i && !expired_o)  cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/epp_handshake.sv
module epp_handshake
  import epp_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LIMIT  = 1000,
  localparam int NB   = WORD_W / 8,
  localparam int NBW  = $clog2(NB) + 1,
  localparam int IDXW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic              is_addr_i,
  input  logic [NBW-1:0]    nbytes_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              wait_i,
  input  logic [7:0]        pd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tout_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [7:0]        byte_o,
  output logic              oe_o,
  output logic              nwrite_o,
  output logic              naddr_stb_o,
  output logic              ndata_stb_o
);
  hs_state_e         st_q;
  logic [IDXW-1:0]   idx_q;
  logic [NBW-1:0]    nb_q;
  logic              wr_q, adr_q, done_q, tout_q;
  logic [WORD_W-1:0] wbuf_q, rbuf_q;
  logic              tmr_clr, tmr_run, tmr_exp, last_byte;

  assign tmr_clr   = (st_q == HS_SETUP) || ((st_q == HS_STROBE) && wait_i);
  assign tmr_run   = (st_q == HS_STROBE) || (st_q == HS_RELEASE);
  assign last_byte = (NBW'(idx_q) == (nb_q - NBW'(1)));

  epp_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .run_i(tmr_run), .expired_o(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      idx_q  <= '0;
      nb_q   <= '0;
      wr_q   <= 1'b0;
      adr_q  <= 1'b0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      done_q <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        HS_IDLE: begin
          if (start_i) begin
            st_q   <= HS_SETUP;
            idx_q  <= '0;
            nb_q   <= nbytes_i;
            wr_q   <= is_write_i;
            adr_q  <= is_addr_i;
            wbuf_q <= wdata_i;
            rbuf_q <= mask_i;
            tout_q <= 1'b0;
          end
        end
        HS_SETUP: st_q <= HS_STROBE;
        HS_STROBE: begin
          if (wait_i) begin
            if (!wr_q) rbuf_q[idx_q*8 +: 8] <= pd_i;
            st_q <= HS_RELEASE;
          end else if (tmr_exp) begin
            st_q   <= HS_IDLE;
            done_q <= 1'b1;
            tout_q <= 1'b1;
          end
        end
        HS_RELEASE: begin
          if (!wait_i) begin
            if (last_byte) begin
              st_q   <= HS_IDLE;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + IDXW'(1);
              st_q  <= HS_SETUP;
            end
          end else if (tmr_exp) begin
            st_q   <= HS_IDLE;
            done_q <= 1'b1;
            tout_q <= 1'b1;
          end
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != HS_IDLE);
  assign done_o      = done_q;
  assign tout_o      = tout_q;
  assign rdata_o     = wr_q ? '0 : rbuf_q;
  assign byte_o      = wbuf_q[idx_q*8 +: 8];
  assign oe_o        = wr_q;
  assign nwrite_o    = !(busy_o && wr_q);
  assign naddr_stb_o = !((st_q == HS_STROBE) && adr_q);
  assign ndata_stb_o = !((st_q == HS_STROBE) && !adr_q);
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_eng_pkg::*;
#(
  parameter int WORD_W          = 32,
  parameter int TIMEOUT_CYCLES  = 1000,
  localparam int NB  = WORD_W / 8,
  localparam int NBW = $clog2(NB) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic [1:0]        req_size,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic [7:0]        ext_status_i,
  output logic [7:0]        ctrl_o,
  output logic              ctrl_upd_o,
  output logic              data_upd_o,
  output logic [7:0]        pd_o,
  input  logic [7:0]        pd_i,
  output logic              pd_oe_o,
  output logic              nwrite_o,
  output logic              naddr_stb_o,
  output logic              ndata_stb_o,
  input  logic              wait_i
);
  logic [7:0]        ctrl_q, data_q;
  logic              tout_flag_q, rsp_valid_q, ctrl_upd_q, data_upd_q;
  logic [WORD_W-1:0] rsp_data_q;

  logic              accept, is_epp, gate_allow;
  logic [1:0]        gate_size;
  logic [NBW-1:0]    gate_nb;
  logic [WORD_W-1:0] gate_ones;
  logic              imm_rsp;
  logic [WORD_W-1:0] imm_data;
  logic [7:0]        ctrl_wval;

  logic              hs_busy, hs_done, hs_tout, hs_oe, hs_nwr, hs_nas, hs_nds;
  logic [WORD_W-1:0] hs_rdata;
  logic [7:0]        hs_byte;

  assign req_ready = !rsp_valid_q && !hs_busy && !hs_done;
  assign accept    = req_valid && req_ready;
  assign is_epp    = (req_addr == OFS_EADR) || (req_addr == OFS_EDAT);
  assign gate_size = (req_addr == OFS_EADR) ? 2'd0 : req_size;
  assign ctrl_wval = req_wdata[7:0] | CTRL_FORCE;

  epp_gate #(.WORD_W(WORD_W)) u_gate (
    .ctrl_i(ctrl_q), .is_write_i(req_write), .size_i(gate_size),
    .allow_o(gate_allow), .nbytes_o(gate_nb), .ones_o(gate_ones)
  );

  epp_handshake #(.WORD_W(WORD_W), .LIMIT(TIMEOUT_CYCLES)) u_hs (
    .clk(clk), .rst_n(rst_n),
    .start_i(accept && is_epp && gate_allow),
    .is_write_i(req_write), .is_addr_i(req_addr == OFS_EADR),
    .nbytes_i(gate_nb), .mask_i(gate_ones), .wdata_i(req_wdata),
    .wait_i(wait_i), .pd_i(pd_i),
    .busy_o(hs_busy), .done_o(hs_done), .tout_o(hs_tout), .rdata_o(hs_rdata),
    .byte_o(hs_byte), .oe_o(hs_oe), .nwrite_o(hs_nwr),
    .naddr_stb_o(hs_nas), .ndata_stb_o(hs_nds)
  );

  // immediate replies: everything except a qualified bus cycle
  always_comb begin
    imm_rsp  = 1'b1;
    imm_data = '0;
    case (req_addr)
      OFS_DATA: if (!req_write)
                  imm_data = WORD_W'(ctrl_q[DIR_BIT] ? pd_i : data_q);
      OFS_STAT: if (!req_write)
                  imm_data = WORD_W'({ext_status_i[7:1], tout_flag_q});
      OFS_CTRL: if (!req_write) imm_data = WORD_W'(ctrl_q);
      OFS_EADR, OFS_EDAT: begin
        imm_rsp = !gate_allow;
        if (!req_write) imm_data = gate_ones;
      end
      default: if (!req_write) imm_data = WORD_W'(8'hFF);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= CTRL_INIT;
      data_q      <= 8'hFF;
      tout_flag_q <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      ctrl_upd_q  <= 1'b0;
      data_upd_q  <= 1'b0;
    end else begin
      ctrl_upd_q <= 1'b0;
      data_upd_q <= 1'b0;
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      if (hs_done) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= hs_rdata;
        if (hs_tout) tout_flag_q <= 1'b1;
      end
      if (accept) begin
        if (imm_rsp) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= imm_data;
        end
        if (req_write) begin
          case (req_addr)
            OFS_DATA: if (req_wdata[7:0] != data_q) begin
                        data_q     <= req_wdata[7:0];
                        data_upd_q <= 1'b1;
                      end
            OFS_STAT: if (req_wdata[0]) tout_flag_q <= 1'b0;
            OFS_CTRL: if (ctrl_wval != ctrl_q) begin
                        ctrl_q     <= ctrl_wval;
                        ctrl_upd_q <= 1'b1;
                      end
            default: ;
          endcase
        end
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_data_q;
  assign ctrl_o      = ctrl_q;
  assign ctrl_upd_o  = ctrl_upd_q;
  assign data_upd_o  = data_upd_q;
  assign pd_o        = hs_busy ? hs_byte : data_q;
  assign pd_oe_o     = hs_busy ? hs_oe : !ctrl_q[DIR_BIT];
  assign nwrite_o    = hs_nwr;
  assign naddr_stb_o = hs_nas;
  assign ndata_stb_o = hs_nds;
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [2:0]        req_addr,
  input logic [WORD_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic [7:0]        ctrl_o,
  input logic              ctrl_upd_o,
  input logic              pd_oe_o,
  input logic              nwrite_o,
  input logic              naddr_stb_o,
  input logic              ndata_stb_o,
  input logic              tout_flag_q
);
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!naddr_stb_o && !ndata_stb_o));

  p_read_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!naddr_stb_o || !ndata_stb_o) && nwrite_o) |-> !pd_oe_o);

  p_setup_before_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(naddr_stb_o && ndata_stb_o) |-> $stable(nwrite_o));

  p_rsp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_ready_blocked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

  p_ctrl_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[7:6] == 2'b11);

  p_ctrl_upd_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_upd_o |-> (ctrl_o != $past(ctrl_o)));

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == 3'd1 && req_wdata[0])
      |=> !tout_flag_q);
endmodule

bind epp_cycle_engine epp_cycle_engine_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .ctrl_o(ctrl_o), .ctrl_upd_o(ctrl_upd_o), .pd_oe_o(pd_oe_o),
  .nwrite_o(nwrite_o), .naddr_stb_o(naddr_stb_o), .ndata_stb_o(ndata_stb_o),
  .tout_flag_q(tout_flag_q)
);

// File: tb/epp_cycle_engine_test.sv
`timescale 1ns/1ps
module epp_cycle_engine_test;
  localparam int TMO = 40;
  localparam int DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [2:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  ext_status = 8'hB1;
  logic [7:0]  pd_in = 8'h00;
  logic        wait_in = 1'b0;
  logic        req_ready, rsp_valid, ctrl_upd, data_upd, pd_oe, nwr, nas, nds;
  logic [31:0] rsp_rdata;
  logic [7:0]  ctrl, pd_out;

  always #2 clk = ~clk;

  epp_cycle_engine #(.WORD_W(32), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .ext_status_i(ext_status), .ctrl_o(ctrl),
    .ctrl_upd_o(ctrl_upd), .data_upd_o(data_upd), .pd_o(pd_out), .pd_i(pd_in),
    .pd_oe_o(pd_oe), .nwrite_o(nwr), .naddr_stb_o(nas), .ndata_stb_o(nds),
    .wait_i(wait_in)
  );

  int checks = 0, errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  bit   quiet = 1;        // model: no strobe may be seen
  int   outstanding = 0;  // model: replies owed
  int   strobe_falls = 0, ctrl_pulses = 0, data_pulses = 0;
  int   served = 0, serve_limit = 1000000;
  logic [8:0] wlog[$];    // {is_addr, byte}
  logic [7:0] rdq[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // peripheral responder
  int  dcnt = 0;
  logic stb_prev = 1'b0, nwr_prev = 1'b1;
  always @(negedge clk) begin
    logic stb;
    stb = !nas || !nds;
    if (rst_n) begin
      if (stb && !wait_in && served < serve_limit) begin
        if (dcnt == DLY) begin
          dcnt = 0;
          if (!nwr) wlog.push_back({!nas, pd_out});
          else pd_in = (rdq.size() > 0) ? rdq.pop_front() : 8'hEE;
          wait_in = 1'b1;
          served++;
        end else dcnt++;
      end else if (!stb && wait_in) begin
        if (dcnt == DLY) begin dcnt = 0; wait_in = 1'b0; end
        else dcnt++;
      end else dcnt = 0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    logic stb;
    stb = !nas || !nds;
    if (rst_n) begin
      if (quiet && stb) begin
        checks++; errors++;
        $display("FAIL R2/R3 actual=strobe expected=quiet bus");
      end
      if (rsp_valid && outstanding == 0) begin
        checks++; errors++;
        $display("FAIL R13 actual=rsp_valid expected=no reply owed");
      end
      if (stb && nwr && pd_oe) begin
        checks++; errors++;
        $display("FAIL R7 actual=oe 1 expected=0 during read strobe");
      end
      if (stb && !stb_prev) begin
        strobe_falls++;
        check("R6 setup", {31'd0, nwr_prev}, {31'd0, nwr});
      end
      if (ctrl_upd) ctrl_pulses++;
      if (data_upd) data_pulses++;
      stb_prev = stb;
      nwr_prev = nwr;
    end
  end

  task automatic access(input logic w, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    outstanding = 1;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    @(negedge clk);
    outstanding = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] wd);
    logic [31:0] d;
    access(1'b1, a, 2'd0, wd, d);
  endtask

  logic [31:0] rd;
  int f0, p0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl_o", {24'd0, ctrl}, 32'hCC);
    check("R1 pins", {28'd0, nas, nds, nwr, pd_oe}, 32'hF);
    check("R1 pd_o", {24'd0, pd_out}, 32'hFF);
    access(0, 3'd2, 0, 0, rd); check("R1 ctrl read", rd, 32'hCC);
    access(0, 3'd1, 0, 0, rd); check("R9 status flag clear", rd, 32'hB0);

    // R2 write rejected with reset control
    f0 = strobe_falls;
    access(1, 3'd4, 2'd2, 32'hDEADBEEF, rd);
    check("R2 rejected write reply", rd, 0);
    access(1, 3'd3, 0, 32'h5, rd);
    check("R2 no strobes", strobe_falls - f0, 0);

    // R11 control write
    p0 = ctrl_pulses;
    wr(3'd2, 32'h04);
    check("R11 forced bits", {24'd0, ctrl}, 32'hC4);
    wr(3'd2, 32'hC4);
    check("R11 pulse only on change", ctrl_pulses - p0, 1);

    // R3 reads rejected under write pattern
    access(0, 3'd4, 2'd0, 0, rd); check("R3 reject 8", rd, 32'hFF);
    access(0, 3'd4, 2'd1, 0, rd); check("R3 reject 16", rd, 32'hFFFF);
    access(0, 3'd4, 2'd3, 0, rd); check("R3 reject 32", rd, 32'hFFFFFFFF);

    // R4 address write, R5/R6 wide data write
    quiet = 0;
    wlog.delete();
    access(1, 3'd3, 2'd2, 32'h777777A5, rd);
    check("R4 one addr byte", wlog.size(), 1);
    if (wlog.size() > 0) check("R4 addr strobe byte", wlog[0], {1'b1, 8'hA5});
    wlog.delete();
    access(1, 3'd4, 2'd2, 32'h11223344, rd);
    check("R5 four bytes", wlog.size(), 4);
    if (wlog.size() == 4) begin
      check("R5 byte0", wlog[0], {1'b0, 8'h44});
      check("R5 byte3", wlog[3], {1'b0, 8'h11});
    end
    wlog.delete();
    access(1, 3'd4, 2'd1, 32'hAAAABBCC, rd);
    check("R5 half two bytes", wlog.size(), 2);
    if (wlog.size() == 2) check("R5 half byte1", wlog[1], {1'b0, 8'hBB});
    quiet = 1;

    // R12 data latch
    p0 = data_pulses;
    wr(3'd0, 32'h3C);
    wr(3'd0, 32'h3C);
    check("R12 single pulse", data_pulses - p0, 1);
    check("R12 pd_o", {24'd0, pd_out}, 32'h3C);
    access(0, 3'd0, 0, 0, rd); check("R12 latch read", rd, 32'h3C);

    // read pattern
    wr(3'd2, 32'h24);
    pd_in = 8'h77;
    @(negedge clk);
    access(0, 3'd0, 0, 0, rd); check("R12 reverse read", rd, 32'h77);
    f0 = strobe_falls;
    access(1, 3'd4, 0, 32'h12, rd); check("R2 write under read pattern", strobe_falls - f0, 0);

    // R7/R5 reads
    quiet = 0;
    rdq = '{8'h5A, 8'hC3};
    access(0, 3'd4, 2'd1, 0, rd); check("R5 R7 read 16", rd, 32'hC35A);
    rdq = '{8'h9E};
    access(0, 3'd3, 2'd2, 0, rd); check("R4 R7 addr read", rd, 32'h9E);

    // R8 read timeout after two bytes
    rdq = '{8'h01, 8'h02};
    serve_limit = served + 2;
    access(0, 3'd4, 2'd2, 0, rd); check("R8 partial read", rd, 32'hFFFF0201);
    check("R8 bus released", {30'd0, nas, nds}, 32'h3);
    serve_limit = 1000000;
    quiet = 1;
    access(0, 3'd1, 0, 0, rd); check("R9 status flag set", rd, 32'hB1);
    wr(3'd1, 32'h00);
    access(0, 3'd1, 0, 0, rd); check("R10 bit0=0 keeps flag", rd, 32'hB1);
    wr(3'd1, 32'h01);
    access(0, 3'd1, 0, 0, rd); check("R10 clear", rd, 32'hB0);

    // R8 write timeout after first byte drops the rest
    wr(3'd2, 32'h04);
    quiet = 0;
    wlog.delete();
    serve_limit = served + 1;
    access(1, 3'd4, 2'd2, 32'hCAFEF00D, rd);
    check("R8 remaining dropped", wlog.size(), 1);
    serve_limit = 1000000;
    quiet = 1;
    access(0, 3'd1, 0, 0, rd); check("R8 flag after write", rd, 32'hB1);

    // R13 back-pressure
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 3'd2;
    @(negedge clk);
    req_valid = 0; outstanding = 1;
    repeat (3) @(negedge clk);
    check("R13 reply held", {31'd0, rsp_valid}, 1);
    check("R13 ready low", {31'd0, req_ready}, 0);
    check("R13 data", rsp_rdata, 32'hC4);
    rsp_ready = 1;
    @(negedge clk);
    outstanding = 0;
    @(negedge clk);
    check("R13 reply taken", {31'd0, rsp_valid}, 0);

    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 150000) begin
      if (!done) begin
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule